// File: doc/BRIEF.md
# Gated Two-Source Clock Fanout

This block takes two single-ended clock sources, routes one of them according to a select input, and distributes the chosen clock to a set of true/complement output pairs. Four pairs is the default. An enable request may arrive at any time with no relation to either clock. Before it reaches the gate, it is retimed to the chosen clock. As a result, turning the outputs on or off never produces a shortened high pulse.

The request is first captured on a rising edge of the chosen clock. It then moves to a second stage on the next falling edge, and that second stage drives a single AND gate. Because the gate control only changes while the clock is low, every pulse on a true output is a complete high phase of the source. While the gate is closed, every true output sits low and every complement output sits high. An active-low asynchronous reset clears both stages, so the outputs come out of reset parked.

Top module: `gated_clk_fanout`

## Requirements
- R1: With `srcSel` at 0 the outputs are derived from `clkIn0`; with `srcSel` at 1 they are derived from `clkIn1`.
- R2: While the gate is open, every bit of `qTrue` equals the current level of the chosen clock.
- R3: Every bit of `qComp` is always the inverse of the matching bit of `qTrue`. In particular, `qComp` is all ones whenever the chosen clock is low.
- R4: While the gate is closed, `qTrue` is all zeros and `qComp` is all ones.
- R5: A change of `enReq` reaches the outputs only after a rising edge and then a falling edge of the chosen clock. Every high pulse on `qTrue` lasts exactly one high phase of the chosen clock, and `qTrue` is never high while that clock is low.
- R6: While the chosen clock is stopped, at either level, a change of `enReq` leaves the outputs unchanged. After the clock restarts, the change takes effect only after a rising edge and then a falling edge.
- R7: While `rstN` is 0 the gate is closed whatever `enReq` is. After release with `enReq` at 1, the first high phase is blocked and the second passes.
- R8: All output pairs carry the same value at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn0 | input | 1 | Clock source chosen when `srcSel` is 0 |
| clkIn1 | input | 1 | Clock source chosen when `srcSel` is 1 |
| srcSel | input | 1 | Source select |
| enReq | input | 1 | Asynchronous output enable request, 1 opens the gate |
| rstN | input | 1 | Asynchronous active-low reset of the enable retiming |
| qTrue | output | NUM_PAIRS | True outputs of the pairs |
| qComp | output | NUM_PAIRS | Complement outputs of the pairs |

## Verification
The clocked properties run on the selected clock rebuilt inside the checker. They therefore assume that `srcSel` only moves while both sources are low, so that the rebuilt clock has no partial phase. The stimulus changes `srcSel` only at points where both sources sit low together. `enReq` is left free: it is toggled half a nanosecond before or after clock edges and also while a clock is held still. This keeps it clear of the exact edge instant, where the capture outcome would be a simulator race rather than a property of the design.

// File: rtl/gcf_pkg.sv
`timescale 1ns/1ps
package gcf_pkg;
  // Strobe passed from the enable control to the fanout path.
  typedef struct packed {
    logic gateOn;  // 1: let the selected clock through
  } gateCtl_t;
endpackage

// File: rtl/gcf_enable_sync.sv
`timescale 1ns/1ps
module gcf_enable_sync
  import gcf_pkg::*;
(
  input  logic     selClk,
  input  logic     rstN,
  input  logic     enReq,
  output gateCtl_t ctl
);
  logic capEn;   // request sampled on the rising edge
  logic gateEn;  // moved across on the falling edge, drives the gate

  always_ff @(posedge selClk or negedge rstN) begin
    if (!rstN) capEn <= 1'b0;
    else       capEn <= enReq;
  end

  // Updated only on the falling edge, so the gate never moves while the clock is high.
  always_ff @(negedge selClk or negedge rstN) begin
    if (!rstN) gateEn <= 1'b0;
    else       gateEn <= capEn;
  end

  assign ctl.gateOn = gateEn;
endmodule

// File: rtl/gcf_fanout_path.sv
`timescale 1ns/1ps
module gcf_fanout_path
  import gcf_pkg::*;
#(
  parameter int NUM_PAIRS = 4
) (
  input  logic                 clkIn0,
  input  logic                 clkIn1,
  input  logic                 srcSel,
  input  gateCtl_t             ctl,
  output logic                 selClk,
  output logic [NUM_PAIRS-1:0] qTrue,
  output logic [NUM_PAIRS-1:0] qComp
);
  localparam int LAST_PAIR = NUM_PAIRS - 1;

  logic gatedClk;

  assign selClk   = srcSel ? clkIn1 : clkIn0;
  assign gatedClk = selClk & ctl.gateOn;

  for (genvar i = 0; i <= LAST_PAIR; i++) begin : g_pair
    assign qTrue[i] = gatedClk;
    assign qComp[i] = ~gatedClk;
  end
endmodule

// File: rtl/gated_clk_fanout.sv
`timescale 1ns/1ps
module gated_clk_fanout
  import gcf_pkg::*;
#(
  parameter int NUM_PAIRS = 4
) (
  input  logic                 clkIn0,
  input  logic                 clkIn1,
  input  logic                 srcSel,
  input  logic                 enReq,
  input  logic                 rstN,
  output logic [NUM_PAIRS-1:0] qTrue,
  output logic [NUM_PAIRS-1:0] qComp
);
  logic     selClk;
  gateCtl_t ctl;

  gcf_fanout_path #(.NUM_PAIRS(NUM_PAIRS)) u_path (
    .clkIn0 (clkIn0),
    .clkIn1 (clkIn1),
    .srcSel (srcSel),
    .ctl    (ctl),
    .selClk (selClk),
    .qTrue  (qTrue),
    .qComp  (qComp)
  );

  gcf_enable_sync u_sync (
    .selClk (selClk),
    .rstN   (rstN),
    .enReq  (enReq),
    .ctl    (ctl)
  );
endmodule

// File: rtl/gated_clk_fanout_chk.sv
`timescale 1ns/1ps
module gated_clk_fanout_chk #(
  parameter int NUM_PAIRS = 4
) (
  input logic                 clkIn0,
  input logic                 clkIn1,
  input logic                 srcSel,
  input logic                 enReq,
  input logic                 rstN,
  input logic [NUM_PAIRS-1:0] qTrue,
  input logic [NUM_PAIRS-1:0] qComp
);
  logic chkClk;
  logic unusedEn;
  assign chkClk   = srcSel ? clkIn1 : clkIn0;
  assign unusedEn = enReq;

  // R5: just before each rising edge the clock is low, so no true output may be high.
  p_parked_before_rise_r5: assert property (@(posedge chkClk) disable iff (!rstN)
    qTrue == '0);

  // R3: the complements are high while the clock is low.
  p_comp_high_before_rise_r3: assert property (@(posedge chkClk) disable iff (!rstN)
    qComp == '1);

  // R3: complement is the inverse during the high phase.
  p_pair_inverse_r3: assert property (@(negedge chkClk) disable iff (!rstN)
    qComp == ~qTrue);

  // R8: all pairs agree.
  p_pairs_match_r8: assert property (@(negedge chkClk) disable iff (!rstN)
    (qTrue == '0) || (qTrue == '1));

  // R7: reset keeps the outputs parked even through a high phase.
  p_reset_parks_r7: assert property (@(negedge chkClk)
    !rstN |-> (qTrue == '0));
endmodule

bind gated_clk_fanout gated_clk_fanout_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clkIn0 (clkIn0),
  .clkIn1 (clkIn1),
  .srcSel (srcSel),
  .enReq  (enReq),
  .rstN   (rstN),
  .qTrue  (qTrue),
  .qComp  (qComp)
);

// File: tb/gated_clk_fanout_test.sv
`timescale 1ns/1ps
module gated_clk_fanout_test;
  localparam int NP = 4;
  // {srcSel, enReq, expected gate open}
  localparam logic [2:0] VEC [8] = '{3'b011, 3'b111, 3'b000, 3'b100,
                                     3'b011, 3'b100, 3'b111, 3'b000};

  logic clkIn0 = 1'b0, clkIn1 = 1'b0, srcSel = 1'b0, enReq = 1'b1, rstN = 1'b1;
  logic [NP-1:0] qTrue, qComp;
  int checks = 0, errors = 0, halfCnt = 0;
  bit widthOn = 1'b0;
  realtime riseAt = 0;

  gated_clk_fanout #(.NUM_PAIRS(NP)) uut (
    .clkIn0 (clkIn0), .clkIn1 (clkIn1), .srcSel (srcSel),
    .enReq  (enReq),  .rstN   (rstN),   .qTrue  (qTrue), .qComp (qComp)
  );

  task automatic check(input bit ok, input string req,
                       input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkPins(input string req, input logic [NP-1:0] expT);
    check(qTrue === expT, req, qTrue, expT);
    check(qComp === ~expT, {req, " R3"}, qComp, ~expT);
  endtask

  function automatic logic selLevel();
    return srcSel ? clkIn1 : clkIn0;
  endfunction

  // One 2 ns half period of clkIn0 (250 MHz). clkIn1 toggles every third half.
  // flipAt: 0 none, 1 flip enReq 0.5 ns before the edge, 2 flip 0.5 ns after it.
  task automatic stepHalf(input int flipAt = 0);
    #0.5; if (flipAt == 1) enReq = ~enReq;
    #0.5; clkIn0 = ~clkIn0; halfCnt++; if (halfCnt % 3 == 0) clkIn1 = ~clkIn1;
    #0.5; if (flipAt == 2) enReq = ~enReq;
    #0.5;
  endtask

  task automatic alignLow();
    while (halfCnt % 6 != 0) stepHalf();
  endtask

  // R5: every true high pulse is one full high phase of the selected source.
  always @(posedge qTrue[0]) riseAt = $realtime;
  always @(negedge qTrue[0]) begin
    real w, e;
    if (widthOn) begin
      w = $realtime - riseAt;
      e = srcSel ? 6.0 : 2.0;
      checks++;
      if (w < e - 0.01 || w > e + 0.01) begin
        errors++;
        $display("FAIL R5: high pulse width actual %f expected %f", w, e);
      end
    end
  end

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R7: reset parks the outputs even with enReq high.
    #0.2 rstN = 1'b0;
    #0.3;
    for (int i = 0; i < 6; i++) begin
      stepHalf();
      checkPins("R7 reset", '0);
    end
    alignLow();
    rstN = 1'b1;
    stepHalf(); checkPins("R7 first high blocked", '0);
    stepHalf(); checkPins("R7", '0);
    stepHalf(); checkPins("R7 second high passes", '1);
    stepHalf();

    // Vector walk: R1, R2, R4.
    widthOn = 1'b1;
    for (int v = 0; v < 8; v++) begin
      alignLow();
      srcSel = VEC[v][2];
      enReq  = VEC[v][1];
      for (int i = 0; i < 12; i++) stepHalf();
      for (int i = 0; i < 12; i++) begin
        stepHalf();
        checkPins(VEC[v][1] ? "R1 R2 R8" : "R1 R4 R8", {NP{VEC[v][0] & selLevel()}});
      end
    end

    // R5 latency: disable just before a rising edge.
    alignLow(); srcSel = 1'b0; enReq = 1'b1;
    for (int i = 0; i < 6; i++) stepHalf();
    stepHalf(1); checkPins("R5 high phase after late disable is whole", '1);
    stepHalf();  checkPins("R5", '0);
    stepHalf();  checkPins("R5 disabled after rise+fall", '0);
    stepHalf();
    // R5 latency: enable just after a rising edge.
    stepHalf(2); checkPins("R5 enable missed this rise", '0);
    stepHalf();  checkPins("R5", '0);
    stepHalf();  checkPins("R5 gate still closed", '0);
    stepHalf();  checkPins("R5", '0);
    stepHalf();  checkPins("R5 enabled after rise+fall", '1);
    stepHalf();

    // R5: random enable toggling on both sources.
    for (int s = 0; s < 2; s++) begin
      alignLow(); srcSel = s[0];
      for (int i = 0; i < 240; i++) begin
        stepHalf(int'($urandom_range(0, 2)));
        check(qComp === ~qTrue, "R3 random", qComp, ~qTrue);
        if (!selLevel()) check(qTrue === '0, "R5 low phase", qTrue, '0);
      end
    end

    // R6: clock stopped high, then low.
    widthOn = 1'b0;
    alignLow(); srcSel = 1'b0; enReq = 1'b1;
    for (int i = 0; i < 4; i++) stepHalf();
    stepHalf(); checkPins("R6 running high", '1);
    #7 enReq = 1'b0;
    #7 checkPins("R6 stopped high ignores disable", '1);
    stepHalf(); checkPins("R6", '0);
    stepHalf(); checkPins("R6 first rise after change still passes", '1);
    stepHalf();
    stepHalf(); checkPins("R6 disabled after rise+fall", '0);
    stepHalf();
    #9 enReq = 1'b1;
    #9 checkPins("R6 stopped low ignores enable", '0);
    stepHalf(); checkPins("R6 gate closed on first rise", '0);
    stepHalf();
    stepHalf(); checkPins("R6 enabled after rise+fall", '1);
    stepHalf();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule